// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This unit decides which NaN a two-operand binary32 operation should return. Each operation's two operands reach it together, and at least one of them is a NaN. It sorts each operand into one of three classes: signaling NaN, quiet NaN or ordinary number. It then picks one operand under the active propagation policy. If the chosen operand is signaling, the unit makes it quiet. It also raises an invalid-operation flag whenever a signaling NaN took part.

Three inputs set the behaviour. The first is a polarity input that defines what the top fraction bit means. With the polarity input low, a 1 in the top fraction bit marks a quiet NaN (2008 style). With it high, a 1 there marks a signaling NaN (legacy style). The second is a 2-bit policy select. The third is a default-NaN mode that forces a fixed canonical NaN onto the result. The result and the flag are registered, so the answer comes out one clock after the request.

Top module: `nanprop_unit`

## Requirements
- R1: With `legacy_pol` = 0, an operand whose exponent bits [30:23] are all ones and whose fraction [22:0] is nonzero is quiet when bit 22 is 1 and signaling when bit 22 is 0.
- R2: With `legacy_pol` = 1, such an operand is signaling when bit 22 is 1 and quiet when bit 22 is 0. Values whose exponent is not all ones, and infinities, are never NaNs.
- R3: `invalid` is 1 exactly when at least one operand is a signaling NaN under the active polarity.
- R4: With `dflt_mode` = 1, the result is always the default NaN, and `invalid` still follows R3.
- R5: Policy 0 (ordered), and the reserved code 3: return A if A is signaling, else B if B is signaling, else A if A is quiet, else B.
- R6: Policy 1 (first NaN): return A if A is any NaN, otherwise return B.
- R7: Policy 2 (magnitude): for a signaling NaN paired with a quiet NaN, return the quiet one. For two NaNs of the same class, return the one whose bits [30:0] are larger. For a NaN paired with a number, return the NaN.
- R8: Under policy 2, when two NaNs of the same class have equal bits [30:0], return the operand whose sign bit is 0.
- R9: With `legacy_pol` = 0, a chosen signaling NaN is returned with bit 22 set and all other bits unchanged. The default NaN is 0x7FC00000.
- R10: With `legacy_pol` = 1, a chosen signaling NaN is replaced by the default NaN 0x7FBFFFFF.
- R11: `valid_out` equals `valid_in` of the previous clock. Reset clears `valid_out`, `result` and `invalid`. Both `result` and `invalid` hold their values while `valid_in` is 0.
- R12: A chosen quiet NaN is returned bit for bit, sign included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| legacy_pol | input | 1 | 1: top fraction bit set means signaling |
| policy | input | 2 | 0 ordered, 1 first NaN, 2 magnitude, 3 as 0 |
| dflt_mode | input | 1 | Force the default NaN onto the result |
| valid_out | output | 1 | Result is valid |
| result | output | 32 | Chosen, quieted NaN |
| invalid | output | 1 | A signaling NaN was present |

## Verification
The assertions assume that whenever `valid_in` is high at least one operand is a NaN under the polarity in force. Given that assumption, every registered result is a NaN, and its top fraction bit matches the quiet encoding. The assertions also assume that reset is held for the first cycles with `valid_in` low. The stimulus keeps to both conditions: it sweeps every ordered pair from a fixed set of ten operand patterns under both polarities, all four policy codes and both default modes, and it drops the pairs in which neither operand is a NaN.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    typedef enum logic [1:0] {
        NC_NUM   = 2'd0,
        NC_QUIET = 2'd1,
        NC_SIG   = 2'd2
    } nan_cls_e;

    typedef enum logic [1:0] {
        PP_ORDERED = 2'd0,
        PP_FIRST   = 2'd1,
        PP_MAG     = 2'd2,
        PP_RSVD    = 2'd3
    } pick_policy_e;

    typedef struct packed {
        nan_cls_e cls;
        logic     sign;
    } op_info_t;

    function automatic logic cls_is_sig(input nan_cls_e c);
        return c == NC_SIG;
    endfunction

    function automatic logic cls_is_quiet(input nan_cls_e c);
        return c == NC_QUIET;
    endfunction

    function automatic logic cls_is_nan(input nan_cls_e c);
        return c != NC_NUM;
    endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W-1:0] mag,
    input  logic                    legacy_pol,
    output nan_cls_e                cls
);
    logic exp_full;
    logic frac_nz;
    logic top_bit;

    assign exp_full = &mag[FRAC_W +: EXP_W];
    assign frac_nz  = |mag[FRAC_W-1:0];
    assign top_bit  = mag[FRAC_W-1];

    always_comb begin
        if (!(exp_full && frac_nz)) begin
            cls = NC_NUM;
        end else if (top_bit ^ legacy_pol) begin
            cls = NC_QUIET;
        end else begin
            cls = NC_SIG;
        end
    end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
    import nanprop_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  op_info_t     info_a,
    input  op_info_t     info_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  pick_policy_e policy,
    output logic         take_b
);
    logic a_wins_mag;

    // Larger magnitude wins; on a tie the positive operand wins.
    always_comb begin
        if (mag_a > mag_b) begin
            a_wins_mag = 1'b1;
        end else if (mag_a < mag_b) begin
            a_wins_mag = 1'b0;
        end else begin
            a_wins_mag = !info_a.sign && info_b.sign;
        end
    end

    always_comb begin
        unique case (policy)
            PP_FIRST: begin
                take_b = !cls_is_nan(info_a.cls);
            end
            PP_MAG: begin
                if (cls_is_sig(info_a.cls)) begin
                    if (cls_is_sig(info_b.cls)) begin
                        take_b = !a_wins_mag;
                    end else begin
                        take_b = cls_is_quiet(info_b.cls);
                    end
                end else if (cls_is_quiet(info_a.cls)) begin
                    if (cls_is_quiet(info_b.cls)) begin
                        take_b = !a_wins_mag;
                    end else begin
                        take_b = 1'b0;
                    end
                end else begin
                    take_b = 1'b1;
                end
            end
            default: begin
                if (cls_is_sig(info_a.cls)) begin
                    take_b = 1'b0;
                end else if (cls_is_sig(info_b.cls)) begin
                    take_b = 1'b1;
                end else if (cls_is_quiet(info_a.cls)) begin
                    take_b = 1'b0;
                end else begin
                    take_b = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/nanprop_finish.sv
module nanprop_finish
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [FP_W-1:0] chosen,
    input  nan_cls_e        chosen_cls,
    input  logic            legacy_pol,
    input  logic            dflt_mode,
    output logic [FP_W-1:0] result
);
    localparam logic [FP_W-1:0] DFLT_NEW =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FP_W-1:0] DFLT_OLD =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [FP_W-1:0] QUIET_MASK =
        {{(FP_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [FP_W-1:0] dflt_nan;

    assign dflt_nan = legacy_pol ? DFLT_OLD : DFLT_NEW;

    always_comb begin
        if (dflt_mode) begin
            result = dflt_nan;
        end else if (cls_is_sig(chosen_cls)) begin
            result = legacy_pol ? dflt_nan : (chosen | QUIET_MASK);
        end else begin
            result = chosen;
        end
    end
endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
    import nanprop_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  logic            legacy_pol,
    input  logic [1:0]      policy,
    input  logic            dflt_mode,
    output logic            valid_out,
    output logic [FP_W-1:0] result,
    output logic            invalid
);
    localparam int FRAC_W = FP_W - 1 - EXP_W;
    localparam int MAG_W  = FP_W - 1;
    localparam int N_OPS  = 2;

    logic [FP_W-1:0] ops [N_OPS];
    nan_cls_e        cls [N_OPS];
    op_info_t        info [N_OPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_op
        nanprop_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_cls (
            .mag       (ops[gi][MAG_W-1:0]),
            .legacy_pol(legacy_pol),
            .cls       (cls[gi])
        );
        assign info[gi] = '{cls: cls[gi], sign: ops[gi][FP_W-1]};
    end

    logic            take_b;
    logic [FP_W-1:0] chosen;
    nan_cls_e        chosen_cls;
    logic [FP_W-1:0] res_c;
    logic            inv_c;

    nanprop_pick #(
        .MAG_W(MAG_W)
    ) u_pick (
        .info_a(info[0]),
        .info_b(info[1]),
        .mag_a (op_a[MAG_W-1:0]),
        .mag_b (op_b[MAG_W-1:0]),
        .policy(pick_policy_e'(policy)),
        .take_b(take_b)
    );

    assign chosen     = take_b ? op_b : op_a;
    assign chosen_cls = take_b ? cls[1] : cls[0];
    assign inv_c      = cls_is_sig(cls[0]) || cls_is_sig(cls[1]);

    nanprop_finish #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W)
    ) u_fin (
        .chosen    (chosen),
        .chosen_cls(chosen_cls),
        .legacy_pol(legacy_pol),
        .dflt_mode (dflt_mode),
        .result    (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result  <= res_c;
                invalid <= inv_c;
            end
        end
    end
endmodule

// File: rtl/nanprop_unit_chk.sv
module nanprop_unit_chk #(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            valid_in,
    input logic [FP_W-1:0] op_a,
    input logic            legacy_pol,
    input logic            dflt_mode,
    input logic            valid_out,
    input logic [FP_W-1:0] result,
    input logic            invalid
);
    localparam int FRAC_W = FP_W - 1 - EXP_W;
    localparam logic [FP_W-1:0] DFLT_NEW =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FP_W-1:0] DFLT_OLD =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    // R11: valid_out follows valid_in by one clock
    a_r11_valid_rise: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    a_r11_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    // R11: result and flag hold without a request
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(invalid)));
    // R4: default mode forces the canonical NaN
    a_r4_default: assert property (@(posedge clk) disable iff (rst)
        (valid_in && dflt_mode) |=>
            (result == ($past(legacy_pol) ? DFLT_OLD : DFLT_NEW)));
    // R3: a signaling first operand under 2008 polarity raises the flag
    a_r3_sig_a: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !legacy_pol && (&op_a[FRAC_W +: EXP_W])
         && !op_a[FRAC_W-1] && (|op_a[FRAC_W-2:0])) |=> invalid);
    // R12: every delivered result is a NaN
    a_r12_result_nan: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> ((&result[FRAC_W +: EXP_W]) && (|result[FRAC_W-1:0])));
    // R9: under 2008 polarity the delivered NaN is quiet
    a_r9_quiet_new: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !legacy_pol) |=> result[FRAC_W-1]);
    // R10: under legacy polarity the delivered NaN is quiet
    a_r10_quiet_old: assert property (@(posedge clk) disable iff (rst)
        (valid_in && legacy_pol) |=> !result[FRAC_W-1]);
endmodule

bind nanprop_unit nanprop_unit_chk #(
    .FP_W (FP_W),
    .EXP_W(EXP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .legacy_pol(legacy_pol),
    .dflt_mode (dflt_mode),
    .valid_out (valid_out),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/nanprop_unit_test.sv
module nanprop_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        legacy_pol = 1'b0;
    logic [1:0]  policy = 2'd0;
    logic        dflt_mode = 1'b0;
    logic        valid_out;
    logic [31:0] result;
    logic        invalid;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nanprop_unit uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
        .legacy_pol(legacy_pol), .policy(policy), .dflt_mode(dflt_mode),
        .valid_out(valid_out), .result(result), .invalid(invalid)
    );

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0: return 32'h7FC00001;
            1: return 32'hFFC00001;
            2: return 32'h7F800005;
            3: return 32'hFF800005;
            4: return 32'h7FE00000;
            5: return 32'h7F812345;
            6: return 32'h3F800000;
            7: return 32'hFF800000;
            8: return 32'h00000000;
            default: return 32'h7FC00000;
        endcase
    endfunction

    // 0 number, 1 quiet, 2 signaling (R1, R2)
    function automatic int kind(input logic [31:0] v, input logic lg);
        if (v[30:23] != 8'hFF || v[22:0] == 23'd0) return 0;
        if (v[22] != lg) return 1;
        return 2;
    endfunction

    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic lg, input logic [1:0] pd,
                                          input logic dn);
        int ka, kb;
        logic pick_b, a_big, inv;
        logic [31:0] dfl, src;
        int ks;
        ka = kind(a, lg);
        kb = kind(b, lg);
        inv = (ka == 2) || (kb == 2);
        dfl = lg ? 32'h7FBFFFFF : 32'h7FC00000;
        if (a[30:0] != b[30:0]) a_big = (a[30:0] > b[30:0]);
        else a_big = (a[31] == 1'b0) && (b[31] == 1'b1);
        if (pd == 2'd1) begin
            pick_b = (ka == 0);
        end else if (pd == 2'd2) begin
            if (ka == 0) pick_b = 1'b1;
            else if (kb == 0) pick_b = 1'b0;
            else if (ka != kb) pick_b = (kb == 1);
            else pick_b = !a_big;
        end else begin
            if (ka == 2) pick_b = 1'b0;
            else if (kb == 2) pick_b = 1'b1;
            else if (ka == 1) pick_b = 1'b0;
            else pick_b = 1'b1;
        end
        src = pick_b ? b : a;
        ks  = pick_b ? kb : ka;
        if (dn) return {inv, dfl};
        if (ks == 2) return {inv, lg ? dfl : (src | 32'h00400000)};
        return {inv, src};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic lg,
                       input logic [1:0] pd, input logic dn);
        @(negedge clk);
        op_a = a; op_b = b; legacy_pol = lg; policy = pd; dflt_mode = dn;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic run_check(input string tag, input logic [31:0] a, input logic [31:0] b,
                             input logic lg, input logic [1:0] pd, input logic dn);
        logic [32:0] e;
        e = model(a, b, lg, pd, dn);
        run(a, b, lg, pd, dn);
        check({tag, " valid"}, {31'd0, valid_out}, 32'd1);
        check({tag, " result"}, result, e[31:0]);
        check({tag, " R3 flag"}, {31'd0, invalid}, {31'd0, e[32]});
    endtask

    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset valid", {31'd0, valid_out}, 32'd0);
        check("R11 reset result", result, 32'd0);
        check("R11 reset flag", {31'd0, invalid}, 32'd0);
        rst = 1'b0;

        // R1: 2008 polarity, signaling A quieted by setting bit 22 (R9)
        run_check("R1 R9", 32'h7F800005, 32'h7FC00001, 1'b0, 2'd0, 1'b0);
        check("R1 R9 value", result, 32'h7FC00005);
        // R2: legacy polarity, bit 22 set is signaling -> default (R10)
        run_check("R2 R10", 32'h7FC00000, 32'h3F800000, 1'b1, 2'd0, 1'b0);
        check("R2 R10 value", result, 32'h7FBFFFFF);
        // R2: legacy polarity, bit 22 clear is quiet, returned as is (R12)
        run_check("R2 R12", 32'hFF800005, 32'h00000000, 1'b1, 2'd0, 1'b0);
        check("R12 value", result, 32'hFF800005);
        check("R2 no flag", {31'd0, invalid}, 32'd0);
        // R8: equal magnitude, positive operand wins either way round
        run_check("R8 a", 32'hFFC00001, 32'h7FC00001, 1'b0, 2'd2, 1'b0);
        check("R8 a value", result, 32'h7FC00001);
        run_check("R8 b", 32'h7FC00001, 32'hFFC00001, 1'b0, 2'd2, 1'b0);
        check("R8 b value", result, 32'h7FC00001);
        // R4: default mode still reports the flag
        run_check("R4", 32'h7F800005, 32'h7FC00001, 1'b0, 2'd1, 1'b1);
        check("R4 value", result, 32'h7FC00000);

        // R11: hold while idle
        @(negedge clk);
        op_a = 32'h7F812345; op_b = 32'h7F812345; legacy_pol = 1'b1; dflt_mode = 1'b0;
        @(negedge clk);
        check("R11 idle valid", {31'd0, valid_out}, 32'd0);
        check("R11 hold result", result, 32'h7FC00000);
        check("R11 hold flag", {31'd0, invalid}, 32'd1);

        // Sweep: R5 (codes 0 and 3), R6, R7, R4, R9, R10, R12
        for (int lg = 0; lg < 2; lg++) begin
            for (int pd = 0; pd < 4; pd++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    for (int i = 0; i < 10; i++) begin
                        for (int j = 0; j < 10; j++) begin
                            logic [31:0] a, b;
                            string tag;
                            a = pattern(i);
                            b = pattern(j);
                            if (kind(a, lg[0]) == 0 && kind(b, lg[0]) == 0) continue;
                            if (dn != 0) tag = "R4";
                            else if (pd == 1) tag = "R6";
                            else if (pd == 2) tag = "R7";
                            else tag = "R5";
                            run_check(tag, a, b, lg[0], pd[1:0], dn[0]);
                        end
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule